// File: doc/BRIEF.md
# Precise-exception history buffer

This block is a circular undo queue that sits beside the register file of an out-of-order core. Every instruction is written at the tail when it issues. The entry holds the instruction's tag, whether it writes a register, which register that is, and the value the register held before the instruction. Execution units report completion by tag in any order. The queue releases entries only from the head, in program order, and releases at most the two oldest entries in a cycle.

When an exception is raised against a tag that is in the queue, the block stops issue and retirement. It then walks the queue from the youngest entry back to the faulting one, handling one entry per cycle. For each entry that has a destination it drives a restore write (register index and old value) toward the register file. This returns the architectural state to the point just before the faulting instruction. The entries it walked are discarded, and the tail resumes at the faulting entry's slot.

Tags of live entries are unique; keeping them unique is the issuer's duty.

Top module: `hist_rollback_buf`

## Requirements
- R1: While reset is held and on the first cycle after it, the queue is empty, `iss_ready` is high, and `ret0_valid`, `ret1_valid`, `restore_valid` and `rollback_done` are low.
- R2: An issue is accepted on a cycle where `iss_valid` and `iss_ready` are both high, and it is appended at the tail. `iss_ready` is low when DEPTH entries are held, while a rollback walk is in progress, and on any cycle with `exc_valid` high.
- R3: A completion (`cmp_valid` with `cmp_tag`) marks the matching valid entry done without removing it. A completion for an entry already done, or for an unknown tag, changes nothing.
- R4: Entries retire only from the head and only when done. `ret0_valid`/`ret0_tag` report the oldest entry and `ret1_valid`/`ret1_tag` report the second oldest, which is released in the same cycle only if both are done. The strobes appear one cycle after the clock edge that sees the done state, and `ret1_valid` never appears without `ret0_valid`.
- R5: A slot freed by retirement is reusable. Retirement at the head and an accepted issue at the tail may happen in the same cycle.
- R6: An exception (`exc_valid`) whose tag matches a valid entry, raised while no walk is running, starts a walk on the next edge. The walk visits one entry per cycle, from youngest to faulting inclusive. For a visited entry with a destination, `restore_valid` pulses one cycle after its visit edge, with `restore_reg` = its destination index and `restore_data` = its saved old value. An entry without a destination produces no pulse.
- R7: A walk blocks retirement and issue, and ignores further exceptions. `rollback_done` is a one-cycle pulse aligned with the last visit's restore slot. Afterwards the queue holds exactly the entries older than the faulting one, and the next issue follows them.
- R8: An exception whose tag matches no valid entry starts no walk and produces no restore write and no `rollback_done`.
- R9: Completions that arrive during the exception cycle or during a walk are recorded for entries that survive the rollback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_tag | input | TAG_W | Tag of the issuing instruction |
| iss_has_dst | input | 1 | Instruction writes a register |
| iss_dst | input | REG_W | Destination register index |
| iss_old | input | DATA_W | Prior value of the destination register |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | TAG_W | Tag of the completed instruction |
| exc_valid | input | 1 | Exception report |
| exc_tag | input | TAG_W | Tag of the faulting instruction |
| ret0_valid | output | 1 | Oldest entry retired |
| ret0_tag | output | TAG_W | Tag of that entry |
| ret1_valid | output | 1 | Second-oldest entry retired in the same cycle |
| ret1_tag | output | TAG_W | Tag of that entry |
| restore_valid | output | 1 | Restore write toward the register file |
| restore_reg | output | REG_W | Register index to restore |
| restore_data | output | DATA_W | Value to write back |
| rollback_done | output | 1 | One-cycle pulse at the end of a rollback |

## Verification
The bench builds the block with DEPTH=4, TAG_W=4, REG_W=5 and DATA_W=32. A depth of four brings a full queue, pointer wrap and a rollback from the head within a handful of cycles. Sixteen tags against four slots leave plenty of tags that are absent from the queue, so exceptions and completions that miss are easy to produce. A behavioural queue model is compared against every output on every cycle, across directed cases and a long random mix of issues, completions and exceptions.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

  // Walk controller state: normal operation or rollback in progress.
  typedef enum logic {
    RB_IDLE = 1'b0,
    RB_WALK = 1'b1
  } rb_state_e;

endpackage

// File: rtl/hrb_flags.sv
// Per-slot control bits kept in flops so that every slot can be searched
// and cleared in the same cycle.
module hrb_flags #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_idx,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       wr_has_dst,
  input  logic                       done_en,
  input  logic [$clog2(DEPTH)-1:0]   done_idx,
  input  logic [DEPTH-1:0]           clr_mask,
  output logic [DEPTH-1:0]           valid_o,
  output logic [DEPTH-1:0]           done_o,
  output logic [DEPTH-1:0]           hasdst_o,
  output logic [TAG_W-1:0]           tag_o [DEPTH]
);
  localparam int IDX_W = $clog2(DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_o[g]  <= 1'b0;
        done_o[g]   <= 1'b0;
        hasdst_o[g] <= 1'b0;
      end else begin
        if (done_en && done_idx == IDX_W'(g)) done_o[g] <= 1'b1;
        if (clr_mask[g]) begin
          valid_o[g] <= 1'b0;
          done_o[g]  <= 1'b0;
        end
        if (wr_en && wr_idx == IDX_W'(g)) begin
          valid_o[g]  <= 1'b1;
          done_o[g]   <= 1'b0;
          hasdst_o[g] <= wr_has_dst;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) tag_o[g] <= wr_tag;
    end
  end

endmodule

// File: rtl/hrb_lookup.sv
// Associative search of the live tags; tags of live entries are unique.
module hrb_lookup #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4
) (
  input  logic [DEPTH-1:0]           valid_i,
  input  logic [TAG_W-1:0]           tag_i [DEPTH],
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [$clog2(DEPTH)-1:0]   idx
);
  localparam int IDX_W = $clog2(DEPTH);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (valid_i[i] && tag_i[i] == key) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/hrb_payload_ram.sv
// Simple dual-port storage for destination index and old value,
// written at issue and read synchronously by the rollback walker.
module hrb_payload_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 37
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [$clog2(DEPTH)-1:0]   waddr,
  input  logic [WIDTH-1:0]           wdata,
  input  logic [$clog2(DEPTH)-1:0]   raddr,
  output logic [WIDTH-1:0]           rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hist_rollback_buf.sv
module hist_rollback_buf
  import hrb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 4,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              iss_has_dst,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [DATA_W-1:0] iss_old,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              exc_valid,
  input  logic [TAG_W-1:0]  exc_tag,
  output logic              ret0_valid,
  output logic [TAG_W-1:0]  ret0_tag,
  output logic              ret1_valid,
  output logic [TAG_W-1:0]  ret1_tag,
  output logic              restore_valid,
  output logic [REG_W-1:0]  restore_reg,
  output logic [DATA_W-1:0] restore_data,
  output logic              rollback_done
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PAY_W = REG_W + DATA_W;

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] ring_prev(input logic [IDX_W-1:0] p);
    return (p == '0) ? IDX_W'(DEPTH - 1) : p - IDX_W'(1);
  endfunction

  // Number of slots from 'from' up to (not including) 'to', going forward.
  function automatic logic [CNT_W-1:0] span(input logic [IDX_W-1:0] from,
                                            input logic [IDX_W-1:0] to);
    if (to >= from) return CNT_W'(to - from);
    return CNT_W'(DEPTH) - CNT_W'(from) + CNT_W'(to);
  endfunction

  // Queue pointers and walk state
  logic [IDX_W-1:0] head, tail, ptr, stop, head1;
  logic [CNT_W-1:0] count, n_ret;
  rb_state_e        state;

  // Slot status
  logic [DEPTH-1:0] slot_v, slot_d, slot_h, clr_mask;
  logic [TAG_W-1:0] slot_tag [DEPTH];

  // Decisions for this cycle
  logic             walking, full, iss_fire, exc_take, ret_ok, r0, r1, done_en;
  logic             exc_hit, cmp_hit;
  logic [IDX_W-1:0] exc_idx, cmp_idx;
  logic [PAY_W-1:0] ram_rd;

  assign walking   = (state == RB_WALK);
  assign full      = (count == CNT_W'(DEPTH));
  assign iss_ready = !full && !walking && !exc_valid;
  assign iss_fire  = iss_valid && iss_ready;
  assign exc_take  = exc_valid && exc_hit && !walking;
  assign head1     = ring_next(head);

  // Retirement uses the done bits as they stand before this edge.
  assign ret_ok = !walking && !exc_take;
  assign r0     = ret_ok && slot_v[head] && slot_d[head];
  assign r1     = r0 && slot_v[head1] && slot_d[head1];
  assign n_ret  = CNT_W'(r0) + CNT_W'(r1);

  assign done_en = cmp_valid && cmp_hit && !slot_d[cmp_idx];

  always_comb begin
    clr_mask = '0;
    if (r0)      clr_mask[head]  = 1'b1;
    if (r1)      clr_mask[head1] = 1'b1;
    if (walking) clr_mask[ptr]   = 1'b1;
  end

  hrb_flags #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (iss_fire),
    .wr_idx     (tail),
    .wr_tag     (iss_tag),
    .wr_has_dst (iss_has_dst),
    .done_en    (done_en),
    .done_idx   (cmp_idx),
    .clr_mask   (clr_mask),
    .valid_o    (slot_v),
    .done_o     (slot_d),
    .hasdst_o   (slot_h),
    .tag_o      (slot_tag)
  );

  hrb_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_exc_find (
    .valid_i (slot_v),
    .tag_i   (slot_tag),
    .key     (exc_tag),
    .hit     (exc_hit),
    .idx     (exc_idx)
  );

  hrb_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cmp_find (
    .valid_i (slot_v),
    .tag_i   (slot_tag),
    .key     (cmp_tag),
    .hit     (cmp_hit),
    .idx     (cmp_idx)
  );

  hrb_payload_ram #(.DEPTH(DEPTH), .WIDTH(PAY_W)) u_payload (
    .clk   (clk),
    .we    (iss_fire),
    .waddr (tail),
    .wdata ({iss_dst, iss_old}),
    .raddr (ptr),
    .rdata (ram_rd)
  );

  assign restore_reg  = ram_rd[PAY_W-1 -: REG_W];
  assign restore_data = ram_rd[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      head          <= '0;
      tail          <= '0;
      ptr           <= '0;
      stop          <= '0;
      count         <= '0;
      state         <= RB_IDLE;
      ret0_valid    <= 1'b0;
      ret0_tag      <= '0;
      ret1_valid    <= 1'b0;
      ret1_tag      <= '0;
      restore_valid <= 1'b0;
      rollback_done <= 1'b0;
    end else begin
      ret0_valid    <= r0;
      ret0_tag      <= slot_tag[head];
      ret1_valid    <= r1;
      ret1_tag      <= slot_tag[head1];
      restore_valid <= walking && slot_h[ptr];
      rollback_done <= 1'b0;

      if (!walking) begin
        if (exc_take) begin
          state <= RB_WALK;
          ptr   <= ring_prev(tail);
          stop  <= exc_idx;
        end else begin
          if (r1)      head <= ring_next(head1);
          else if (r0) head <= head1;
          if (iss_fire) tail <= ring_next(tail);
          count <= count + CNT_W'(iss_fire) - n_ret;
        end
      end else begin
        if (ptr == stop) begin
          state         <= RB_IDLE;
          rollback_done <= 1'b1;
          tail          <= stop;
          count         <= span(head, stop);
        end else begin
          ptr <= ring_prev(ptr);
        end
      end
    end
  end

endmodule

// File: rtl/hrb_checker.sv
module hrb_checker (
  input logic clk,
  input logic rst,
  input logic iss_ready,
  input logic ret0_valid,
  input logic ret1_valid,
  input logic restore_valid,
  input logic rollback_done,
  input logic walking
);

  // R4: the second retirement slot is only used together with the first
  assert_ret_pair_R4: assert property (@(posedge clk) disable iff (rst)
    ret1_valid |-> ret0_valid)
    else $error("ret1 without ret0");

  // R7: no issue may be accepted while the walk runs
  assert_walk_no_issue_R7: assert property (@(posedge clk) disable iff (rst)
    walking |-> !iss_ready)
    else $error("issue open during walk");

  // R7: no retirement strobe follows a walk cycle
  assert_walk_no_retire_R7: assert property (@(posedge clk) disable iff (rst)
    walking |=> !ret0_valid)
    else $error("retire during walk");

  // R6: restore writes only result from walk cycles
  assert_restore_in_walk_R6: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> $past(walking))
    else $error("restore outside walk");

  // R7: completion pulse lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rollback_done |=> !rollback_done)
    else $error("rollback_done longer than one cycle");

  // R7: completion pulse only once the walk has stopped
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    rollback_done |-> !walking)
    else $error("rollback_done while walking");

endmodule

bind hist_rollback_buf hrb_checker u_hrb_checker (
  .clk           (clk),
  .rst           (rst),
  .iss_ready     (iss_ready),
  .ret0_valid    (ret0_valid),
  .ret1_valid    (ret1_valid),
  .restore_valid (restore_valid),
  .rollback_done (rollback_done),
  .walking       (walking)
);

// File: tb/test_hist_rollback_buf.sv
`timescale 1ns/1ps
module test_hist_rollback_buf;
  localparam int DEPTH = 4, TAG_W = 4, REG_W = 5, DATA_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              iss_valid = 0, iss_has_dst = 0, cmp_valid = 0, exc_valid = 0;
  logic [TAG_W-1:0]  iss_tag = 0, cmp_tag = 0, exc_tag = 0;
  logic [REG_W-1:0]  iss_dst = 0;
  logic [DATA_W-1:0] iss_old = 0;
  logic              iss_ready, ret0_valid, ret1_valid, restore_valid, rollback_done;
  logic [TAG_W-1:0]  ret0_tag, ret1_tag;
  logic [REG_W-1:0]  restore_reg;
  logic [DATA_W-1:0] restore_data;

  hist_rollback_buf #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W))
    i_hist_rollback_buf (.*);

  // ---------------- behavioural reference ----------------
  typedef struct {
    logic [TAG_W-1:0]  tag;
    bit                has;
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] old;
    bit                done;
  } ent_t;

  ent_t q[$];
  bit   rb;
  int   rb_stop;
  bit   e_r0v, e_r1v, e_rwv, e_done;
  logic [TAG_W-1:0]  e_r0t, e_r1t;
  logic [REG_W-1:0]  e_rwi;
  logic [DATA_W-1:0] e_rwd;
  int   total = 0, bad = 0, cyc_n = 0;
  bit   seen [16];

  function automatic int find_tag(input logic [TAG_W-1:0] t);
    for (int i = 0; i < q.size(); i++) if (q[i].tag == t) return i;
    return -1;
  endfunction

  function automatic bit exp_ready();
    return (q.size() < DEPTH) && !rb && !exc_valid;
  endfunction

  task automatic apply_cmp();
    if (cmp_valid)
      for (int i = 0; i < q.size(); i++) if (q[i].tag == cmp_tag) q[i].done = 1;
  endtask

  always @(posedge clk) begin : model
    int   pos;
    bit   rr0, rr1, rdy;
    ent_t n;
    e_r0v = 0; e_r1v = 0; e_rwv = 0; e_done = 0;
    if (rst) begin
      q.delete();
      rb = 0;
    end else if (rb) begin
      apply_cmp();
      e_rwv = q[q.size()-1].has;
      e_rwi = q[q.size()-1].dst;
      e_rwd = q[q.size()-1].old;
      void'(q.pop_back());
      if (q.size() == rb_stop) begin rb = 0; e_done = 1; end
    end else begin
      pos = exc_valid ? find_tag(exc_tag) : -1;
      if (pos >= 0) begin
        apply_cmp();
        rb = 1;
        rb_stop = pos;
      end else begin
        rdy = (q.size() < DEPTH) && !exc_valid;
        rr0 = q.size() >= 1 && q[0].done;
        rr1 = rr0 && q.size() >= 2 && q[1].done;
        if (rr0) begin e_r0v = 1; e_r0t = q[0].tag; end
        if (rr1) begin e_r1v = 1; e_r1t = q[1].tag; end
        apply_cmp();
        if (rr0) void'(q.pop_front());
        if (rr1) void'(q.pop_front());
        if (iss_valid && rdy) begin
          n.tag = iss_tag; n.has = iss_has_dst; n.dst = iss_dst; n.old = iss_old; n.done = 0;
          q.push_back(n);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst) begin
      cyc_n++;
      chk(iss_ready === exp_ready(), "R2", "iss_ready", iss_ready, exp_ready());
      chk(ret0_valid === e_r0v, "R4", "ret0_valid", ret0_valid, e_r0v);
      if (e_r0v) chk(ret0_tag === e_r0t, "R3 R4", "ret0_tag", ret0_tag, e_r0t);
      chk(ret1_valid === e_r1v, "R4 R5", "ret1_valid", ret1_valid, e_r1v);
      if (e_r1v) chk(ret1_tag === e_r1t, "R4 R5", "ret1_tag", ret1_tag, e_r1t);
      chk(restore_valid === e_rwv, "R6", "restore_valid", restore_valid, e_rwv);
      if (e_rwv) begin
        chk(restore_reg === e_rwi, "R6", "restore_reg", restore_reg, e_rwi);
        chk(restore_data === e_rwd, "R6", "restore_data", restore_data, e_rwd);
      end
      chk(rollback_done === e_done, "R7", "rollback_done", rollback_done, e_done);
      if (ret0_valid) seen[ret0_tag] = 1;
      if (ret1_valid) seen[ret1_tag] = 1;
      if (cyc_n > 20000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc_n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit iv, input logic [TAG_W-1:0] it, input bit ih,
                       input logic [REG_W-1:0] id, input logic [DATA_W-1:0] io,
                       input bit cv, input logic [TAG_W-1:0] ct,
                       input bit ev, input logic [TAG_W-1:0] et);
    iss_valid = iv; iss_tag = it; iss_has_dst = ih; iss_dst = id; iss_old = io;
    cmp_valid = cv; cmp_tag = ct; exc_valid = ev; exc_tag = et;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic issue(input logic [TAG_W-1:0] t, input bit h,
                       input logic [REG_W-1:0] d, input logic [DATA_W-1:0] o);
    drive(1, t, h, d, o, 0, 0, 0, 0);
  endtask
  task automatic complete(input logic [TAG_W-1:0] t);
    drive(0, 0, 0, 0, 0, 1, t, 0, 0);
  endtask
  task automatic raise(input logic [TAG_W-1:0] t);
    drive(0, 0, 0, 0, 0, 0, 0, 1, t);
  endtask

  function automatic logic [TAG_W-1:0] free_tag();
    for (int t = 0; t < 16; t++) if (find_tag(TAG_W'(t)) < 0) return TAG_W'(t);
    return '0;
  endfunction

  task automatic drain();
    for (int k = 0; k < 200 && (q.size() > 0 || rb); k++) begin
      int pick;
      pick = -1;
      if (!rb) for (int i = q.size() - 1; i >= 0; i--) if (!q[i].done) pick = i;
      if (pick >= 0) complete(q[pick].tag); else idle();
    end
    idle(); idle();
  endtask

  initial begin
    bit               iv, ih, cv, ev;
    logic [TAG_W-1:0] it, ct, et;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R1: state right after reset
    chk(iss_ready === 1'b1, "R1", "iss_ready", iss_ready, 1);
    chk(ret0_valid === 1'b0 && ret1_valid === 1'b0, "R1", "retire strobes", ret0_valid, 0);
    chk(restore_valid === 1'b0 && rollback_done === 1'b0, "R1", "rollback outputs", restore_valid, 0);

    // R3 R4: out-of-order completion, in-order paired retirement
    issue(1, 1, 3, 32'h11); issue(2, 1, 4, 32'h22); issue(3, 1, 5, 32'h33);
    complete(2); complete(2); idle();
    complete(1); complete(3); idle(); idle();

    // R2 R5: fill, refuse, then issue alongside retirement
    issue(4, 1, 1, 32'h44); issue(5, 0, 2, 32'h55); issue(6, 1, 6, 32'h66);
    issue(7, 1, 7, 32'h77); issue(8, 1, 8, 32'h88);
    chk(iss_ready === 1'b0, "R2", "full refuses", iss_ready, 0);
    complete(4); idle();
    drive(1, 9, 1, 9, 32'h99, 1, 5, 0, 0);
    drive(1, 10, 1, 10, 32'haa, 1, 6, 0, 0);
    drain();

    // R6 R7 R9: rollback from the middle with activity during the walk
    for (int i = 0; i < 16; i++) seen[i] = 0;
    issue(1, 1, 1, 32'hA1); issue(2, 0, 2, 32'hA2);
    issue(3, 1, 7, 32'hA3); issue(4, 1, 9, 32'hA4);
    complete(4);
    raise(2);
    drive(1, 12, 1, 3, 32'hBB, 1, 1, 1, 1);
    idle(); idle(); idle(); idle();
    chk(seen[1] == 1, "R9", "completion during walk retires tag 1", seen[1], 1);
    chk(seen[4] == 0, "R7", "rolled-back tag 4 never retires", seen[4], 0);
    issue(5, 1, 4, 32'hC5); complete(5); idle(); idle();
    drain();

    // R8: exception with an absent tag
    issue(2, 1, 2, 32'hD2); issue(3, 1, 3, 32'hD3);
    raise(12);
    for (int k = 0; k < 5; k++) begin
      chk(restore_valid === 1'b0 && rollback_done === 1'b0, "R8", "no rollback", restore_valid, 0);
      idle();
    end
    chk(iss_ready === 1'b1, "R8", "issue still open", iss_ready, 1);
    drain();

    // R6 R7: rollback from the head of a full queue
    issue(5, 1, 11, 32'hE5); issue(6, 1, 12, 32'hE6);
    issue(7, 0, 13, 32'hE7); issue(8, 1, 14, 32'hE8);
    chk(iss_ready === 1'b0, "R2", "full after four", iss_ready, 0);
    raise(5);
    repeat (6) idle();
    chk(iss_ready === 1'b1, "R7", "queue emptied by head rollback", iss_ready, 1);

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      iv = ($urandom_range(0, 2) != 0);
      it = free_tag();
      ih = $urandom_range(0, 3) != 0;
      cv = $urandom_range(0, 1);
      ct = (q.size() > 0 && $urandom_range(0, 4) != 0) ?
           q[$urandom_range(0, q.size() - 1)].tag : TAG_W'($urandom);
      ev = ($urandom_range(0, 24) == 0);
      et = (q.size() > 0 && $urandom_range(0, 3) != 0) ?
           q[$urandom_range(0, q.size() - 1)].tag : TAG_W'($urandom);
      drive(iv, it, ih, REG_W'($urandom), $urandom, cv, ct, ev, et);
    end
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule